// File: doc/BRIEF.md
# Edge-Timed Phase Comparator with Lock Indication

This block compares the timing of two strobes that already live in a fast system clock domain. One is the divided feedback strobe (`fb_in`) and the other is the divided reference strobe (`ref_in`). A rising edge on either input starts a comparison, and the matching rising edge on the other input ends it. While a comparison is open, one of two active-low correction outputs is held low. If the feedback edge came first, `dn_n` goes low. If the reference edge came first, `up_n` goes low. The low time, counted in clock cycles, equals the separation between the two edges, so a later charge-pump stage can turn it directly into a correction charge.

Each finished comparison yields a pulse width. A lock tracker compares that width with the programmable `lock_window` input. It raises `locked` after a run of consecutive comparisons that each fall within the window, and it drops `locked` as soon as one comparison falls outside.

The controller has three states:
- `ST_IDLE`: no comparison is open.
- `ST_DN`: feedback led, so `dn_n` is low.
- `ST_UP`: reference led, so `up_n` is low.

The transitions are named as follows:
- *open-dn*: `ST_IDLE`→`ST_DN` on a feedback edge alone.
- *open-up*: `ST_IDLE`→`ST_UP` on a reference edge alone.
- *tie*: `ST_IDLE`→`ST_IDLE` when both edges arrive in the same cycle. This is a width-0 comparison.
- *close-dn*: `ST_DN`→`ST_IDLE` on a reference edge.
- *close-up*: `ST_UP`→`ST_IDLE` on a feedback edge.
- *hold*: an extra leading edge while a state is active; the state does not change.

Top module: `pfd_lock_top`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `up_n` and `dn_n` are 1 and `locked` is 0. This also holds when reset interrupts an open comparison.
- R2: A feedback rising edge that is sampled d ≥ 1 cycles before the reference rising edge drives `dn_n` low for exactly d cycles. The low period starts on the clock edge that samples the feedback edge.
- R3: A reference rising edge that is sampled d ≥ 1 cycles before the feedback rising edge drives `up_n` low for exactly d cycles.
- R4: Rising edges of both inputs sampled in the same cycle produce no low time on either output.
- R5: Only rising edges matter. An input held high for several cycles counts as one edge, and its falling edge has no effect on either output.
- R6: Further rising edges of the leading input that arrive before the lagging edge keep the active output low. The width is measured from the first leading edge.
- R7: `up_n` and `dn_n` are never low in the same cycle.
- R8: `locked` rises on the clock edge that completes the `LOCK_COUNT`-th (default 16) consecutive comparison whose width is ≤ `lock_window`. The comparison is inclusive, and tie comparisons count as width 0. Once `locked` is high, it stays high while comparisons remain within the window.
- R9: A comparison whose width is > `lock_window` clears `locked` on the clock edge that completes it, and it restarts the run count.
- R10: When the closing edge arrives in the same cycle as a fresh edge of the leading input, the comparison closes. The fresh edge is dropped, and both outputs return high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_in | input | 1 | Divided feedback strobe, synchronous to clk |
| ref_in | input | 1 | Divided reference strobe, synchronous to clk |
| lock_window | input | CNT_W | Largest pulse width, in cycles, that counts as in-lock |
| up_n | output | 1 | Active-low correction: reference leads |
| dn_n | output | 1 | Active-low correction: feedback leads |
| locked | output | 1 | Lock indication |

## Verification
Two functions can fall in the same cycle. One is the closing of an open comparison. The other is either the opening of a new one by a fresh leading edge, or, when idle, the arrival of both edges at once. The bench provokes both cases on purpose: it places the closing reference edge in the same cycle as a second feedback edge, and it drives edges of both inputs together from idle. A scoreboard judges the results. It expects exactly one pulse of the measured width and then both outputs high, with no pulse left hanging. Width-0 tie comparisons are also fed to the lock tracker, to show that they count toward lock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DN   = 2'd2
    } pfd_state_e;

    localparam int PFD_CNT_W_DEF      = 8;
    localparam int PFD_LOCK_COUNT_DEF = 16;

endpackage

// File: rtl/pfd_rise_detect.sv
module pfd_rise_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[i] <= 1'b0;
            end else begin
                prev_q[i] <= sig_in[i];
            end
        end
        assign rise[i] = sig_in[i] & ~prev_q[i];
    end

endmodule

// File: rtl/pfd_state_ctrl.sv
module pfd_state_ctrl
    import pfd_pkg::*;
#(
    parameter int CNT_W = PFD_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fb_rise,
    input  logic             ref_rise,
    output logic             up_n,
    output logic             dn_n,
    output logic             cmp_done,
    output logic [CNT_W-1:0] cmp_width
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    pfd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // next state and comparison result
    always_comb begin
        state_d   = state_q;
        cmp_done  = 1'b0;
        cmp_width = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (fb_rise && ref_rise) begin
                    cmp_done = 1'b1;            // tie
                end else if (fb_rise) begin
                    state_d = ST_DN;            // open-dn
                end else if (ref_rise) begin
                    state_d = ST_UP;            // open-up
                end
            end
            ST_DN: begin
                if (ref_rise) begin
                    state_d   = ST_IDLE;        // close-dn
                    cmp_done  = 1'b1;
                    cmp_width = cnt_q;
                end
            end
            ST_UP: begin
                if (fb_rise) begin
                    state_d   = ST_IDLE;        // close-up
                    cmp_done  = 1'b1;
                    cmp_width = cnt_q;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // open-time counter: holds cycles spent in the active state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_ONE;
        end else if (state_q == ST_IDLE) begin
            cnt_q <= CNT_ONE;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    // outputs
    always_comb begin
        up_n = (state_q != ST_UP);
        dn_n = (state_q != ST_DN);
    end

    a_r4_tie_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (up_n && dn_n && fb_rise && ref_rise) |=> (up_n && dn_n));

    a_r2_fb_lead_opens_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (up_n && dn_n && fb_rise && !ref_rise) |=> !dn_n);

    a_r3_ref_lead_opens_up: assert property (@(posedge clk) disable iff (!rst_n)
        (up_n && dn_n && ref_rise && !fb_rise) |=> !up_n);

    a_r6_dn_holds_on_extra_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (!dn_n && !ref_rise) |=> !dn_n);

    a_r10_close_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!dn_n && ref_rise && fb_rise) |=> (up_n && dn_n));

endmodule

// File: rtl/pfd_lock_track.sv
module pfd_lock_track #(
    parameter int CNT_W      = 8,
    parameter int LOCK_COUNT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_done,
    input  logic [CNT_W-1:0] cmp_width,
    input  logic [CNT_W-1:0] lock_window,
    output logic             locked
);

    localparam int               LC_W      = $clog2(LOCK_COUNT + 1);
    localparam logic [LC_W-1:0]  GOOD_LAST = LC_W'(LOCK_COUNT - 1);
    localparam logic [LC_W-1:0]  GOOD_FULL = LC_W'(LOCK_COUNT);
    localparam logic [LC_W-1:0]  GOOD_ONE  = LC_W'(1);

    logic [LC_W-1:0] good_q;
    logic            in_window;

    assign in_window = (cmp_width <= lock_window);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_q <= '0;
            locked <= 1'b0;
        end else if (cmp_done) begin
            if (in_window) begin
                if (good_q != GOOD_FULL) begin
                    good_q <= good_q + GOOD_ONE;
                end
                if (good_q >= GOOD_LAST) begin
                    locked <= 1'b1;
                end
            end else begin
                good_q <= '0;
                locked <= 1'b0;
            end
        end
    end

    a_r9_wide_clears_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_done && (cmp_width > lock_window)) |=> !locked);

    a_r8_lock_kept_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && cmp_done && (cmp_width <= lock_window)) |=> locked);

    a_r8_lock_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_done) |=> $stable(locked));

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int CNT_W      = PFD_CNT_W_DEF,
    parameter int LOCK_COUNT = PFD_LOCK_COUNT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fb_in,
    input  logic             ref_in,
    input  logic [CNT_W-1:0] lock_window,
    output logic             up_n,
    output logic             dn_n,
    output logic             locked
);

    localparam int IDX_FB  = 0;
    localparam int IDX_REF = 1;

    logic [1:0]       rises;
    logic             cmp_done;
    logic [CNT_W-1:0] cmp_width;

    pfd_rise_detect #(.N(2)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({ref_in, fb_in}),
        .rise   (rises)
    );

    pfd_state_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb_rise   (rises[IDX_FB]),
        .ref_rise  (rises[IDX_REF]),
        .up_n      (up_n),
        .dn_n      (dn_n),
        .cmp_done  (cmp_done),
        .cmp_width (cmp_width)
    );

    pfd_lock_track #(.CNT_W(CNT_W), .LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_done    (cmp_done),
        .cmp_width   (cmp_width),
        .lock_window (lock_window),
        .locked      (locked)
    );

    a_r7_never_both_low: assert property (@(posedge clk) disable iff (!rst_n)
        (up_n || dn_n));

endmodule

// File: tb/pfd_lock_top_tb.sv
module pfd_lock_top_tb;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fb_in = 1'b0;
    logic             ref_in = 1'b0;
    logic [CNT_W-1:0] lock_window = 8'd4;
    logic             up_n, dn_n, locked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int q_dn[$];
    int q_w[$];
    int model_good = 0;
    bit model_lock = 1'b0;

    always #4 clk = ~clk;

    pfd_lock_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fb_in       (fb_in),
        .ref_in      (ref_in),
        .lock_window (lock_window),
        .up_n        (up_n),
        .dn_n        (dn_n),
        .locked      (locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_exp(input bit is_dn, input int w);
        q_dn.push_back(int'(is_dn));
        q_w.push_back(w);
    endtask

    // monitor: measures each low run and pops expected pulse
    int dn_run = 0;
    int up_run = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            dn_run = 0;
            up_run = 0;
        end else begin
            if (!up_n && !dn_n) check(1'b0, "R7 both low", 0, 1);
            if (!dn_n) dn_run++;
            else if (dn_run > 0) begin
                if (q_w.size() == 0) check(1'b0, "R2/R5 unexpected dn pulse", dn_run, 0);
                else begin
                    int d, w;
                    d = q_dn.pop_front();
                    w = q_w.pop_front();
                    check(d == 1, "R2 pulse on dn_n", 1, d);
                    check(w == dn_run, "R2 dn width", dn_run, w);
                end
                dn_run = 0;
            end
            if (!up_n) up_run++;
            else if (up_run > 0) begin
                if (q_w.size() == 0) check(1'b0, "R3/R5 unexpected up pulse", up_run, 0);
                else begin
                    int d, w;
                    d = q_dn.pop_front();
                    w = q_w.pop_front();
                    check(d == 0, "R3 pulse on up_n", 0, d);
                    check(w == up_run, "R3 up width", up_run, w);
                end
                up_run = 0;
            end
        end
    end

    task automatic run_pat(input logic [31:0] fbp, input logic [31:0] refp);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            fb_in  = fbp[i];
            ref_in = refp[i];
        end
        @(negedge clk);
        fb_in  = 1'b0;
        ref_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fb_in = 1'b0;
        ref_in = 1'b0;
        model_good = 0;
        model_lock = 1'b0;
        repeat (2) @(negedge clk);
        check(up_n && dn_n && !locked, "R1 reset state", {up_n, dn_n, locked}, 3'b110);
        rst_n = 1'b1;
        @(negedge clk);
        check(up_n && dn_n && !locked, "R1 after release", {up_n, dn_n, locked}, 3'b110);
    endtask

    // one comparison: single-cycle strobes at given offsets
    task automatic compare(input int fb_off, input int ref_off, input bit chk_lock);
        logic [31:0] fbp, refp;
        int w;
        fbp = '0;
        refp = '0;
        fbp[fb_off] = 1'b1;
        refp[ref_off] = 1'b1;
        w = (fb_off > ref_off) ? fb_off - ref_off : ref_off - fb_off;
        if (w > 0) push_exp(fb_off < ref_off, w);
        if (w <= int'(lock_window)) begin
            model_good++;
            if (model_good >= 16) model_lock = 1'b1;
        end else begin
            model_good = 0;
            model_lock = 1'b0;
        end
        run_pat(fbp, refp);
        if (chk_lock) check(locked == model_lock, "R8/R9 locked", locked, model_lock);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_up();
    end

    initial begin
        do_reset();

        // R2, R3, R4
        compare(0, 3, 1'b0);        // R2 width 3
        compare(5, 1, 1'b0);        // R3 width 4
        compare(2, 2, 1'b0);        // R4 tie, no pulse
        compare(0, 1, 1'b0);        // R2 width 1 boundary
        compare(1, 0, 1'b0);        // R3 width 1 boundary

        // R5: feedback held high ten cycles, one edge only; fall ignored
        push_exp(1'b1, 3);
        run_pat(32'h0000_03FF, 32'h0000_0008);
        check(up_n && dn_n, "R5 level/fall ignored", {up_n, dn_n}, 2'b11);

        // R6: extra leading edges keep output low
        push_exp(1'b1, 7);
        run_pat(32'h0000_0009, 32'h0000_0080);
        push_exp(1'b0, 6);
        run_pat(32'h0000_0040, 32'h0000_0015);

        // R10: closing edge coincides with new leading edge
        push_exp(1'b1, 5);
        run_pat(32'h0000_0021, 32'h0000_0020);
        check(up_n && dn_n, "R10 fresh edge dropped", {up_n, dn_n}, 2'b11);

        // R8/R9: lock behaviour, window 4
        do_reset();
        lock_window = 8'd4;
        for (int k = 0; k < 15; k++) compare(0, 2, 1'b1);   // R8 not yet
        compare(0, 2, 1'b1);                                 // R8 16th: lock
        check(locked == 1'b1, "R8 lock at 16th", locked, 1);
        compare(4, 0, 1'b1);                                 // R8 width == window keeps lock
        compare(5, 0, 1'b1);                                 // R9 wider clears
        check(locked == 1'b0, "R9 wide pulse clears lock", locked, 0);
        for (int k = 0; k < 16; k++) compare(3, 3, 1'b1);   // R8 ties count
        check(locked == 1'b1, "R8 ties relock", locked, 1);

        // R1: reset during open comparison
        @(negedge clk);
        fb_in = 1'b1;
        @(negedge clk);
        fb_in = 1'b0;
        repeat (2) @(negedge clk);
        check(dn_n == 1'b0, "R2 pulse open before reset", dn_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(up_n && dn_n && !locked, "R1 reset mid-pulse", {up_n, dn_n, locked}, 3'b110);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(up_n && dn_n, "R1 idle after reset", {up_n, dn_n}, 2'b11);

        check(q_w.size() == 0, "R2/R3 scoreboard drained", q_w.size(), 0);
        finish_up();
    end

endmodule